// File: doc/BRIEF.md
# Seed Error Recovery Sequencer

This block is a small bus master that sits between a hardware random number source and the logic that consumes its words. It runs the source over a request/acknowledge register bus. It polls the status word, pulls bursts of samples out of the data register and hands each good sample to the consumer on a valid/ready port. When the source signals a seed fault, or returns an all-zero word, the block stops delivering and runs a recovery sequence.

The sequence has two variants, and a parameter fixes which one is built:

- **Conditional reset.** If the source still reports a live fault, the block pulses a reset bit in the control register. It then polls that bit and the live-fault bit until both clear. If the fault had already cleared on its own, the block only wipes the sticky fault flag.
- **Legacy.** The block wipes the sticky flag, drains and drops a fixed number of data words, then reads the status word again to confirm the flag stayed clear.

A recovery that fails, or a poll that outlasts the timeout, halts the block with a fatal indication until reset. Separately, a consumer request that receives no completed burst within the timeout window raises a one-cycle failure pulse.

Register map used on the bus: control at offset 0x0, status at 0x4, data at 0x8. In the status word, bit 0 is data ready, bit 2 is the live seed fault and bit 6 is the sticky seed-fault flag. In the control word, bit 30 is the conditional reset and bit 2 is the enable.

Top module: `seed_recovery_seq`

## Requirements
- R1: After reset `out_valid`, `req_fail`, `fatal` and `bus_req` are all low.
- R2: Once raised, `bus_req` stays high with stable `bus_we`, `bus_addr` and `bus_wdata` until `bus_ack`, and each request is exactly one register access.
- R3: While `need` is high, the block reads status (0x4). If bit 0 is set and bit 6 is clear, it reads exactly BURST_WORDS (default 4) data words (0x8). It presents each word in order on `out_data`, holding it stable while `out_ready` is low.
- R4: A data word of zero is never presented. It ends the burst and starts recovery with a fresh status read.
- R5: Conditional-reset variant, recovery with status bit 2 clear: exactly one status write of 0 (clears bit 6) and no control write, after which sampling resumes.
- R6: Conditional-reset variant, recovery with status bit 2 set: control write of bit 30 plus bit 2, then control write of bit 2 alone. The block then polls control (0x0) until bit 30 reads zero, then polls status until bit 2 is clear, then resumes sampling.
- R7: During that poll, status bit 6 found set after bit 30 has cleared makes `fatal` rise.
- R8: If bit 30 or status bit 2 is still set when TIMEOUT_CYC cycles have passed since the reset pulse, `fatal` rises.
- R9: Legacy variant: recovery writes status 0, performs exactly FLUSH_WORDS (default 12) data reads whose words are dropped, then reads status. Bit 6 set there makes `fatal` rise; otherwise sampling resumes. The legacy variant never writes control.
- R10: With `need` high, TIMEOUT_CYC cycles without a completed burst give a one-cycle `req_fail` pulse, exactly TIMEOUT_CYC cycles after `need` rose or after the previous pulse. A completed burst or a low `need` restarts the count.
- R11: Once `fatal` is high it stays high and `bus_req` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| need | input | 1 | Consumer wants samples |
| out_valid | output | 1 | Sample word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DW | Sample word |
| req_fail | output | 1 | One-cycle pulse: no burst within the window |
| fatal | output | 1 | Recovery failed, block halted |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Register offset |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access complete, read data valid |
| bus_rdata | input | DW | Read data |

## Verification
The hardest situations to reach are the failing ends of recovery. These are a live fault that outlasts the poll window, and a sticky flag that survives the reset or the legacy drain; neither can be caused from the block's own ports. The bench therefore builds a behavioural source model with knobs that inject a fault, set how long the reset bit and live-fault bit take to clear, and pin the sticky flag. Each recovery path and each fatal exit is driven deliberately and observed through the stream, the bus traffic counts and `fatal`.

// File: rtl/seed_recovery_seq.sv
module seed_recovery_seq #(
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int CONDRST     = 1,
  parameter int TIMEOUT_CYC = 10000,
  parameter int FLUSH_WORDS = 12,
  parameter int BURST_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          need,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          req_fail,
  output logic          fatal,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int FW = $clog2(FLUSH_WORDS + 1);
  localparam int BW = $clog2(BURST_WORDS + 1);
  localparam int B_RDY = 0, B_CUR = 2, B_FLAG = 6, B_CRST = 30, B_EN = 2;
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_STAT = AW'(4), A_DATA = AW'(8);

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_DATA, S_PUSH, S_CRSET, S_CRCLR, S_FLAGCLR,
    S_FLUSH, S_CONFIRM, S_POLLCR, S_POLLSR, S_HALT
  } st_t;

  st_t            st;
  logic           req_q, force_q, rec_q, fail_q, bus_op, done, burst_done, rec_expired;
  logic [BW-1:0]  burst;
  logic [FW-1:0]  flush;
  logic [TW-1:0]  req_cnt, rec_cnt;
  logic [DW-1:0]  data_q;

  assign bus_req     = req_q;
  assign done        = bus_ack && req_q;
  assign out_valid   = (st == S_PUSH);
  assign out_data    = data_q;
  assign fatal       = (st == S_HALT);
  assign req_fail    = fail_q;
  assign burst_done  = out_valid && out_ready && (burst == BW'(BURST_WORDS - 1));
  assign rec_expired = (rec_cnt == TW'(TIMEOUT_CYC));

  always_comb begin
    bus_op    = 1'b1;
    bus_we    = 1'b0;
    bus_addr  = A_STAT;
    bus_wdata = '0;
    case (st)
      S_STAT, S_CONFIRM, S_POLLSR: ;
      S_DATA, S_FLUSH:             bus_addr = A_DATA;
      S_POLLCR:                    bus_addr = A_CTRL;
      S_CRSET: begin
        bus_we    = 1'b1;
        bus_addr  = A_CTRL;
        bus_wdata = (DW'(1) << B_CRST) | (DW'(1) << B_EN);
      end
      S_CRCLR: begin
        bus_we    = 1'b1;
        bus_addr  = A_CTRL;
        bus_wdata = DW'(1) << B_EN;
      end
      S_FLAGCLR:                   bus_we = 1'b1;
      default:                     bus_op = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      req_q   <= 1'b0;
      force_q <= 1'b0;
      rec_q   <= 1'b0;
      burst   <= '0;
      flush   <= '0;
      data_q  <= '0;
    end else begin
      if (bus_op && !req_q && !bus_ack) req_q <= 1'b1;
      else if (bus_ack)                 req_q <= 1'b0;
      case (st)
        S_IDLE:
          if (rec_q)     st <= S_POLLCR;
          else if (need) st <= S_STAT;
        S_STAT:
          if (done) begin
            if (bus_rdata[B_FLAG] || force_q) begin
              force_q <= 1'b0;
              st <= (CONDRST != 0 && bus_rdata[B_CUR]) ? S_CRSET : S_FLAGCLR;
            end else if (bus_rdata[B_RDY]) begin
              burst <= '0;
              st    <= S_DATA;
            end else begin
              st <= S_IDLE;
            end
          end
        S_DATA:
          if (done) begin
            if (bus_rdata == '0) begin
              force_q <= 1'b1;
              st      <= S_STAT;
            end else begin
              data_q <= bus_rdata;
              st     <= S_PUSH;
            end
          end
        S_PUSH:
          if (out_ready) begin
            if (burst == BW'(BURST_WORDS - 1)) st <= S_IDLE;
            else begin
              burst <= burst + 1'b1;
              st    <= S_DATA;
            end
          end
        S_CRSET:
          if (done) st <= S_CRCLR;
        S_CRCLR:
          if (done) begin
            rec_q <= 1'b1;
            st    <= S_IDLE;
          end
        S_FLAGCLR:
          if (done) begin
            flush <= '0;
            st    <= (CONDRST != 0) ? S_IDLE : S_FLUSH;
          end
        S_FLUSH:
          if (done) begin
            if (flush == FW'(FLUSH_WORDS - 1)) st <= S_CONFIRM;
            else flush <= flush + 1'b1;
          end
        S_CONFIRM:
          if (done) st <= bus_rdata[B_FLAG] ? S_HALT : S_IDLE;
        S_POLLCR:
          if (done) begin
            if (bus_rdata[B_CRST]) st <= rec_expired ? S_HALT : S_IDLE;
            else                   st <= S_POLLSR;
          end
        S_POLLSR:
          if (done) begin
            if (bus_rdata[B_FLAG])     st <= S_HALT;
            else if (bus_rdata[B_CUR]) st <= rec_expired ? S_HALT : S_IDLE;
            else begin
              rec_q <= 1'b0;
              st    <= S_IDLE;
            end
          end
        default: st <= S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cnt <= '0;
      rec_cnt <= '0;
      fail_q  <= 1'b0;
    end else begin
      fail_q <= 1'b0;
      if (!need || fatal || burst_done) req_cnt <= '0;
      else if (req_cnt == TW'(TIMEOUT_CYC - 1)) begin
        req_cnt <= '0;
        fail_q  <= 1'b1;
      end else req_cnt <= req_cnt + 1'b1;
      if (!rec_q)            rec_cnt <= '0;
      else if (!rec_expired) rec_cnt <= rec_cnt + 1'b1;
    end
  end

  p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_no_zero_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != '0);
  p_fail_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fail |=> !req_fail);
  p_fatal_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
  p_fatal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> !bus_req);
  generate
    if (CONDRST == 0) begin : g_legacy_chk
      p_no_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_addr != A_CTRL);
    end
  endgenerate
endmodule

// File: tb/tb_seed_recovery_seq.sv
module rng_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  logic        inj,
  input  logic        inj_cur,
  input  logic        zreq,
  input  logic        drdy,
  input  logic        stuck,
  input  logic [15:0] crh,
  input  logic [15:0] curh,
  output logic [31:0] idx,
  output int          rdc,
  output int          cwr,
  output int          swr,
  output int          reqt,
  output int          maxrun,
  output int          viol,
  output logic        crseen
);
  logic seis, secs, zp, c30, hold, cw;
  logic [15:0] hc, cc;
  int run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 0; rdata <= 0; idx <= 1; rdc <= 0; cwr <= 0; swr <= 0; reqt <= 0;
      maxrun <= 0; viol <= 0; crseen <= 0; seis <= 0; secs <= 0; zp <= 0;
      c30 <= 0; hold <= 0; cw <= 0; hc <= 0; cc <= 0; run <= 0;
    end else begin
      ack <= 0;
      if (ack && !req) viol <= viol + 1;
      if (inj) begin seis <= 1; secs <= inj_cur; end
      if (zreq) zp <= 1;
      if (hold) begin
        if (hc == 0) begin
          c30 <= 0; hold <= 0; cw <= 1; cc <= curh;
          if (!stuck) seis <= 0;
        end else hc <= hc - 1;
      end
      if (cw) begin
        if (cc == 0) begin secs <= 0; cw <= 0; end
        else cc <= cc - 1;
      end
      if (req && !ack) begin
        ack  <= 1;
        reqt <= reqt + 1;
        if (we) begin
          if (addr == 4'h0) begin
            cwr <= cwr + 1;
            if (wdata[30]) begin c30 <= 1; crseen <= 1; end
            else if (c30 && !hold) begin hold <= 1; hc <= crh; end
          end else if (addr == 4'h4) begin
            swr <= swr + 1;
            if (!wdata[6] && !stuck) seis <= 0;
          end
        end else begin
          case (addr)
            4'h0: rdata <= {1'b0, c30, 30'd4};
            4'h4: begin
              rdata <= {25'd0, seis, 3'd0, secs, 1'b0, drdy};
              run   <= 0;
            end
            4'h8: begin
              rdc <= rdc + 1;
              run <= run + 1;
              if (run + 1 > maxrun) maxrun <= run + 1;
              if (zp) begin rdata <= 0; zp <= 0; end
              else begin rdata <= 32'h5A00_0000 + idx; idx <= idx + 1; end
            end
            default: rdata <= 0;
          endcase
        end
      end
    end
  end
endmodule

module tb_seed_recovery_seq;
  localparam int CLK_P = 10;
  localparam int TMO   = 200;

  logic clk = 0, rst_n = 0;
  always #(CLK_P / 2) clk = ~clk;

  logic        need_c [2];
  logic        rdy    [2];
  logic        ov     [2];
  logic [31:0] od     [2];
  logic        rf     [2];
  logic        fat    [2];
  logic        breq   [2];
  logic        bwe    [2];
  logic [3:0]  baddr  [2];
  logic [31:0] bwd    [2];
  logic        back   [2];
  logic [31:0] brd    [2];
  logic        inj [2], inj_cur [2], zreq [2], drdy [2], stuck [2], crseen [2];
  logic [15:0] crh [2], curh [2];
  logic [31:0] idx [2];
  int          rdc [2], cwr [2], swr [2], reqt [2], maxrun [2], viol [2];

  int nvec = 0, nbad = 0, cyc = 0;
  bit bp_en = 0;
  logic [31:0] q0 [$];
  logic [31:0] q1 [$];

  seed_recovery_seq #(.CONDRST(1), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .need(need_c[0]), .out_valid(ov[0]), .out_ready(rdy[0]),
    .out_data(od[0]), .req_fail(rf[0]), .fatal(fat[0]), .bus_req(breq[0]), .bus_we(bwe[0]),
    .bus_addr(baddr[0]), .bus_wdata(bwd[0]), .bus_ack(back[0]), .bus_rdata(brd[0]));
  seed_recovery_seq #(.CONDRST(0), .TIMEOUT_CYC(TMO)) dut_leg (
    .clk(clk), .rst_n(rst_n), .need(need_c[1]), .out_valid(ov[1]), .out_ready(rdy[1]),
    .out_data(od[1]), .req_fail(rf[1]), .fatal(fat[1]), .bus_req(breq[1]), .bus_we(bwe[1]),
    .bus_addr(baddr[1]), .bus_wdata(bwd[1]), .bus_ack(back[1]), .bus_rdata(brd[1]));

  for (genvar g = 0; g < 2; g++) begin : g_mod
    rng_model m (
      .clk(clk), .rst_n(rst_n), .req(breq[g]), .we(bwe[g]), .addr(baddr[g]), .wdata(bwd[g]),
      .ack(back[g]), .rdata(brd[g]), .inj(inj[g]), .inj_cur(inj_cur[g]), .zreq(zreq[g]),
      .drdy(drdy[g]), .stuck(stuck[g]), .crh(crh[g]), .curh(curh[g]), .idx(idx[g]),
      .rdc(rdc[g]), .cwr(cwr[g]), .swr(swr[g]), .reqt(reqt[g]), .maxrun(maxrun[g]),
      .viol(viol[g]), .crseen(crseen[g]));
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    rdy[0] = bp_en ? (cyc % 3 != 0) : 1'b1;
    rdy[1] = 1'b1;
  end

  always @(negedge clk) begin
    logic [31:0] e;
    if (rst_n && ov[0] && rdy[0]) begin
      if (q0.size() == 0) chk(0, "R3 unexpected word", od[0], 0);
      else begin
        e = q0.pop_front();
        chk(od[0] == e, "R3/R4 stream", od[0], e);
        if (q0.size() == 0) need_c[0] = 0;
      end
    end
    if (rst_n && ov[1] && rdy[1]) begin
      if (q1.size() == 0) chk(0, "R9 unexpected word", od[1], 0);
      else begin
        e = q1.pop_front();
        chk(od[1] == e, "R9 stream", od[1], e);
        if (q1.size() == 0) need_c[1] = 0;
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    for (int u = 0; u < 2; u++) begin
      need_c[u] = 0; inj[u] = 0; inj_cur[u] = 0; zreq[u] = 0; drdy[u] = 1;
      stuck[u] = 0; crh[u] = 16'd20; curh[u] = 16'd30;
    end
    bp_en = 0;
    q0.delete();
    q1.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_words(input int u, input int skip, input int n, input string tag);
    logic [31:0] base;
    int w;
    base = idx[u];
    for (int j = 0; j < n; j++) begin
      if (u == 0) q0.push_back(32'h5A00_0000 + base + skip + j);
      else        q1.push_back(32'h5A00_0000 + base + skip + j);
    end
    need_c[u] = 1;
    w = 0;
    while (need_c[u] && w < 3000) begin @(negedge clk); w++; end
    chk(need_c[u] == 0, tag, w, n);
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse_inj(input int u, input bit cur);
    inj_cur[u] = cur;
    inj[u] = 1;
    @(negedge clk);
    inj[u] = 0;
  endtask

  task automatic wait_fatal(input int u, input int lim, output int n);
    n = 0;
    while (!fat[u] && n < lim) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int cw0, sw0, rd0, rq0, n;
    do_reset();
    // R1
    chk(!ov[0] && !rf[0] && !fat[0] && !breq[0], "R1 reset outputs cond", {ov[0], rf[0], fat[0], breq[0]}, 0);
    chk(!ov[1] && !rf[1] && !fat[1] && !breq[1], "R1 reset outputs legacy", {ov[1], rf[1], fat[1], breq[1]}, 0);

    // R3 normal stream with backpressure, R2 one access per request
    bp_en = 1;
    rd0 = rdc[0];
    run_words(0, 0, 8, "R3 stream done");
    chk(rdc[0] - rd0 == 8, "R2/R3 data reads", rdc[0] - rd0, 8);
    chk(maxrun[0] == 4, "R3 burst limit", maxrun[0], 4);
    chk(viol[0] == 0, "R2 request dropped early", viol[0], 0);

    // R4 zero word
    bp_en = 0;
    cw0 = cwr[0]; sw0 = swr[0];
    zreq[0] = 1; @(negedge clk); zreq[0] = 0;
    run_words(0, 0, 8, "R4 stream after zero");
    chk(swr[0] == sw0 + 1, "R4 recovery status write", swr[0], sw0 + 1);
    chk(cwr[0] == cw0, "R4 no ctrl write", cwr[0], cw0);

    // R5 auto-reset flavour
    cw0 = cwr[0]; sw0 = swr[0];
    pulse_inj(0, 0);
    run_words(0, 0, 8, "R5 stream after flag");
    chk(cwr[0] == cw0, "R5 no ctrl write", cwr[0], cw0);
    chk(swr[0] == sw0 + 1, "R5 single status write", swr[0], sw0 + 1);

    // R6 conditional reset with live fault
    cw0 = cwr[0];
    pulse_inj(0, 1);
    run_words(0, 0, 8, "R6 stream after reset");
    chk(cwr[0] == cw0 + 2, "R6 two ctrl writes", cwr[0], cw0 + 2);
    chk(crseen[0] == 1, "R6 reset bit pulsed", crseen[0], 1);
    chk(fat[0] == 0, "R7 no fatal on clean recovery", fat[0], 0);

    // R7 flag survives reset
    do_reset();
    stuck[0] = 1; crh[0] = 5; curh[0] = 5;
    pulse_inj(0, 1);
    need_c[0] = 1;
    wait_fatal(0, 150, n);
    chk(fat[0] == 1, "R7 fatal on persistent flag", fat[0], 1);
    chk(n < TMO, "R7 fatal before timeout", n, TMO);
    rq0 = reqt[0];
    repeat (50) @(negedge clk);
    chk(reqt[0] == rq0 && fat[0] && !breq[0], "R11 halted quiet", reqt[0], rq0);

    // R8 reset bit never clears
    do_reset();
    crh[0] = 16'hFFFF;
    pulse_inj(0, 1);
    need_c[0] = 1;
    wait_fatal(0, 1000, n);
    chk(fat[0] == 1, "R8 fatal on reset-bit timeout", fat[0], 1);
    chk(n >= TMO, "R8 timeout not early", n, TMO);

    // R8 live fault never clears
    do_reset();
    crh[0] = 5; curh[0] = 16'hFFFF;
    pulse_inj(0, 1);
    need_c[0] = 1;
    wait_fatal(0, 1000, n);
    chk(fat[0] == 1, "R8 fatal on live-fault timeout", fat[0], 1);
    chk(n >= TMO, "R8 timeout not early live", n, TMO);

    // R10 starvation
    do_reset();
    drdy[0] = 0;
    need_c[0] = 1;
    n = 0;
    while (!rf[0] && n < 1000) begin @(negedge clk); n++; end
    chk(n == TMO, "R10 first fail pulse", n, TMO);
    n = 0;
    do begin @(negedge clk); n++; end while (!rf[0] && n < 1000);
    chk(n == TMO, "R10 fail restart", n, TMO);
    need_c[0] = 0;

    // R9 legacy recovery
    do_reset();
    run_words(1, 0, 8, "R9 legacy stream");
    pulse_inj(1, 1);
    run_words(1, 12, 8, "R9 stream after flush");
    chk(cwr[1] == 0, "R9 legacy no ctrl write", cwr[1], 0);
    chk(fat[1] == 0, "R9 no fatal on clean flush", fat[1], 0);

    stuck[1] = 1;
    rd0 = rdc[1];
    pulse_inj(1, 0);
    need_c[1] = 1;
    wait_fatal(1, 300, n);
    chk(fat[1] == 1, "R9 legacy fatal on persistent flag", fat[1], 1);
    chk(rdc[1] - rd0 == 12, "R9 flush count", rdc[1] - rd0, 12);
    rq0 = reqt[1];
    repeat (30) @(negedge clk);
    chk(reqt[1] == rq0, "R11 legacy halted quiet", reqt[1], rq0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule